// File: doc/BRIEF.md
# Two-Level Page Translation Walker

This block turns a 32-bit linear address into a physical address. When paging is on, it looks the address up in a two-level table that lives in ordinary memory. One request is handled at a time. The request carries the linear address, a write flag and a user-mode flag. A directory base register and a paging-enable input set the context.

Without a cached translation, the walker reads a directory entry and then a table entry over a simple valid/ready memory port. It checks the present and permission bits at both levels. Where the accessed or dirty bits are still clear, it writes the updated entry back before it finishes. It then either pulses done with the physical address, or pulses fault with a three-bit error code and the faulting linear address. The physical address and the two fault outputs stay valid until the next result.

A single-entry translation cache keeps the most recent successful walk, so a repeated access to the same page costs no memory traffic. Any write to the directory base register drops the cached entry.

Top module: `page_walker`

## Requirements
- R1: With paging disabled, an accepted request completes with done one cycle after acceptance, the physical address equals the linear address, and no memory access is made.
- R2: After a successful walk, the physical address is the page frame from bits 31..12 of the table entry joined with linear address bits 11..0.
- R3: The directory entry is read at base + 4 × (linear bits 31..22). The table entry is read at (directory entry bits 31..12 shifted left by 12) + 4 × (linear bits 21..12).
- R4: If bit 0 (present) of an entry is clear, the walk stops with a fault and error-code bit 0 = 0. Nothing is written back, and no table read follows a non-present directory entry.
- R5: A user access needs bit 2 set at both levels. A user write also needs bit 1 set at both levels. Supervisor accesses ignore bits 1 and 2. A violation faults with error-code bit 0 = 1.
- R6: A fault is a one-cycle pulse. Error-code bit 1 is the write flag and bit 2 is the user flag. The fault-address output holds the linear address of the request.
- R7: Bit 5 (accessed) of each used entry is written back as the entry with bit 5 set, directory first, and only when it was clear. All write-backs finish before done.
- R8: A successful write sets bit 6 (dirty) of the table entry, in the same write-back as the accessed bit, and only when it was clear.
- R9: After a successful walk, another access to the same page completes one cycle after acceptance with no memory access, provided its permissions allow it and, for a write, the cached dirty bit is set. Otherwise the access walks again.
- R10: Writing the directory base register clears bits 11..0 and empties the cache. A walk that overlaps a base write, including one whose finishing cycle coincides with it, leaves the cache empty. No hit is taken in a cycle where the base is written.
- R11: A memory request holds valid, write enable, address and write data stable until ready. Read data is taken in the cycle ready is high.
- R12: The request ready is high only while the walker is idle, and it drops in the cycle after a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle and accepting |
| reqAddr | input | 32 | Linear address |
| reqWrite | input | 1 | Access is a write |
| reqUser | input | 1 | Access is from user mode |
| pagingOn | input | 1 | Paging enabled |
| dirBaseWe | input | 1 | Write the directory base register |
| dirBaseIn | input | 32 | New directory base value |
| memValid | output | 1 | Memory request valid |
| memReady | input | 1 | Memory accepts or completes the request |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Entry value written back |
| memRdata | input | 32 | Entry value read, valid with memReady |
| doneValid | output | 1 | One-cycle translation-complete pulse |
| physAddr | output | 32 | Physical address |
| faultValid | output | 1 | One-cycle fault pulse |
| faultCode | output | 3 | Error code {user, write, protection} |
| faultAddr | output | 32 | Linear address of the last fault |

## Verification
The cache fill at the end of a walk can land in the same cycle as a write to the directory base register. The flush must win. The bench provokes this by waiting until it sees done, then driving the base write in that same cycle. It also drives a base write one cycle into a stalled walk. In both cases it judges the result by repeating the access to the same page: the repeat must walk again, with two memory reads counted at the port. A control run without any flush shows the same repeat hitting with no traffic.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int ENT_P = 0;
  localparam int ENT_W = 1;
  localparam int ENT_U = 2;
  localparam int ENT_A = 5;
  localparam int ENT_D = 6;

  typedef enum logic [1:0] {PA_LIN, PA_HIT, PA_MEM} paSel_e;

  typedef struct packed {
    logic   latchReq;
    logic   loadPa;
    paSel_e paSel;
    logic   capPde;
    logic   capPte;
    logic   markPte;
    logic   tblSel;
    logic   wrEn;
    logic   setFault;
    logic   faultProt;
    logic   fill;
  } strobes_t;

  typedef struct packed {
    logic hit;
    logic pdeP;
    logic pdeDeny;
    logic pdeNeedA;
    logic pteP;
    logic pteDeny;
    logic pteNeedWb;
  } status_t;
endpackage

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import pw_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     pagingOn,
  input  logic     memReady,
  input  status_t  stat,
  output strobes_t st,
  output logic     reqReady,
  output logic     memValid,
  output logic     memWe,
  output logic     doneValid,
  output logic     faultValid
);
  typedef enum logic [2:0] {S_IDLE, S_DRD, S_DWB, S_TRD, S_TWB, S_DONE, S_FAULT} state_e;
  state_e state, nxt;
  logic walked, walkedNxt;

  always_comb begin
    st = '0;
    nxt = state;
    walkedNxt = walked;
    case (state)
      S_IDLE: if (reqValid) begin
        st.latchReq = 1'b1;
        walkedNxt = 1'b0;
        if (!pagingOn) begin
          st.loadPa = 1'b1; st.paSel = PA_LIN; nxt = S_DONE;
        end else if (stat.hit) begin
          st.loadPa = 1'b1; st.paSel = PA_HIT; nxt = S_DONE;
        end else begin
          nxt = S_DRD;
        end
      end
      S_DRD: if (memReady) begin
        st.capPde = 1'b1;
        if (!stat.pdeP) begin
          st.setFault = 1'b1; nxt = S_FAULT;
        end else if (stat.pdeDeny) begin
          st.setFault = 1'b1; st.faultProt = 1'b1; nxt = S_FAULT;
        end else if (stat.pdeNeedA) begin
          nxt = S_DWB;
        end else begin
          nxt = S_TRD;
        end
      end
      S_DWB: begin
        st.wrEn = 1'b1;
        if (memReady) nxt = S_TRD;
      end
      S_TRD: begin
        st.tblSel = 1'b1;
        if (memReady) begin
          st.capPte = 1'b1;
          st.loadPa = 1'b1; st.paSel = PA_MEM;
          if (!stat.pteP) begin
            st.setFault = 1'b1; nxt = S_FAULT;
          end else if (stat.pteDeny) begin
            st.setFault = 1'b1; st.faultProt = 1'b1; nxt = S_FAULT;
          end else if (stat.pteNeedWb) begin
            nxt = S_TWB;
          end else begin
            nxt = S_DONE; walkedNxt = 1'b1;
          end
        end
      end
      S_TWB: begin
        st.tblSel = 1'b1;
        st.wrEn = 1'b1;
        if (memReady) begin
          st.markPte = 1'b1; nxt = S_DONE; walkedNxt = 1'b1;
        end
      end
      S_DONE: begin
        st.fill = walked;
        nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign reqReady   = (state == S_IDLE);
  assign memValid   = (state == S_DRD) || (state == S_DWB) || (state == S_TRD) || (state == S_TWB);
  assign memWe      = st.wrEn;
  assign doneValid  = (state == S_DONE);
  assign faultValid = (state == S_FAULT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      walked <= 1'b0;
    end else begin
      state  <= nxt;
      walked <= walkedNxt;
    end
  end

  // R12: one request in flight
  assert_one_at_a_time_R12: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
endmodule

// File: rtl/pw_dpath.sv
module pw_dpath
  import pw_pkg::*;
#(
  parameter int PG_W = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobes_t               st,
  output status_t                stat,
  input  logic [PG_W*3-5:0]      reqAddr,
  input  logic                   reqWrite,
  input  logic                   reqUser,
  input  logic                   dirBaseWe,
  input  logic [PG_W*3-5:0]      dirBaseIn,
  input  logic [PG_W*3-5:0]      memRdata,
  output logic [PG_W*3-5:0]      memAddr,
  output logic [PG_W*3-5:0]      memWdata,
  output logic [PG_W*3-5:0]      physAddr,
  output logic [2:0]             faultCode,
  output logic [PG_W*3-5:0]      faultAddr
);
  localparam int IDX_W = PG_W - 2;
  localparam int LA_W  = PG_W + 2 * IDX_W;
  localparam int VPN_W = LA_W - PG_W;
  localparam logic [LA_W-1:0] LOW_MASK = {{VPN_W{1'b0}}, {PG_W{1'b1}}};
  localparam logic [LA_W-1:0] BIT_A = LA_W'(1) << ENT_A;
  localparam logic [LA_W-1:0] BIT_D = LA_W'(1) << ENT_D;

  logic [LA_W-1:0]  laReg, baseReg, walkBase, pdeReg, pteReg, paReg, fAddr;
  logic             wrReg, usrReg, dropFill;
  logic [2:0]       fCode;
  logic             cValid, cUser, cWrite, cDirty;
  logic [VPN_W-1:0] cTag, cFrame;
  logic [LA_W-1:0]  ent, dirOff, tblAddr, wbData;
  logic             uOk, wOk;

  // status towards the controller, decoded from the entry on the read port
  assign ent  = memRdata;
  assign uOk  = pdeReg[ENT_U] & ent[ENT_U];
  assign wOk  = pdeReg[ENT_W] & ent[ENT_W];
  assign stat.pdeP      = ent[ENT_P];
  assign stat.pdeDeny   = usrReg && (!ent[ENT_U] || (wrReg && !ent[ENT_W]));
  assign stat.pdeNeedA  = !ent[ENT_A];
  assign stat.pteP      = ent[ENT_P];
  assign stat.pteDeny   = usrReg && (!uOk || (wrReg && !wOk));
  assign stat.pteNeedWb = !ent[ENT_A] || (wrReg && !ent[ENT_D]);
  assign stat.hit = cValid && !dirBaseWe && (cTag == reqAddr[LA_W-1:PG_W])
                 && (!reqUser || (cUser && (!reqWrite || cWrite)))
                 && (!reqWrite || cDirty);

  // entry addresses and write-back values
  assign dirOff   = LA_W'({laReg[LA_W-1 -: IDX_W], 2'b00});
  assign tblAddr  = {pdeReg[LA_W-1:PG_W], laReg[PG_W +: IDX_W], 2'b00};
  assign memAddr  = st.tblSel ? tblAddr : (walkBase + dirOff);
  assign wbData   = st.tblSel ? (pteReg | BIT_A | (wrReg ? BIT_D : '0)) : (pdeReg | BIT_A);
  assign memWdata = st.wrEn ? wbData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      laReg <= '0; wrReg <= 1'b0; usrReg <= 1'b0;
      baseReg <= '0; walkBase <= '0; dropFill <= 1'b0;
      pdeReg <= '0; pteReg <= '0; paReg <= '0;
      fCode <= '0; fAddr <= '0;
      cValid <= 1'b0; cUser <= 1'b0; cWrite <= 1'b0; cDirty <= 1'b0;
      cTag <= '0; cFrame <= '0;
    end else begin
      if (st.latchReq) begin
        laReg    <= reqAddr;
        wrReg    <= reqWrite;
        usrReg   <= reqUser;
        walkBase <= dirBaseWe ? (dirBaseIn & ~LOW_MASK) : baseReg;
      end
      if (dirBaseWe) begin
        baseReg  <= dirBaseIn & ~LOW_MASK;
        dropFill <= 1'b1;
      end else if (st.latchReq) begin
        dropFill <= 1'b0;
      end
      if (st.loadPa) begin
        case (st.paSel)
          PA_LIN:  paReg <= reqAddr;
          PA_HIT:  paReg <= {cFrame, reqAddr[PG_W-1:0]};
          default: paReg <= {memRdata[LA_W-1:PG_W], laReg[PG_W-1:0]};
        endcase
      end
      if (st.capPde)  pdeReg <= memRdata;
      if (st.capPte)  pteReg <= memRdata;
      if (st.markPte) pteReg <= wbData;
      if (st.setFault) begin
        fCode <= {usrReg, wrReg, st.faultProt};
        fAddr <= laReg;
      end
      if (dirBaseWe) begin
        cValid <= 1'b0;
      end else if (st.fill && !dropFill) begin
        cValid <= 1'b1;
        cTag   <= laReg[LA_W-1:PG_W];
        cFrame <= pteReg[LA_W-1:PG_W];
        cUser  <= pdeReg[ENT_U] & pteReg[ENT_U];
        cWrite <= pdeReg[ENT_W] & pteReg[ENT_W];
        cDirty <= pteReg[ENT_D];
      end
    end
  end

  assign physAddr  = paReg;
  assign faultCode = fCode;
  assign faultAddr = fAddr;

  // R7 R8: table write-back carries accessed, and dirty on a write
  assert_wb_bits_R7: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrEn && st.tblSel) |-> (memWdata[ENT_A] && memWdata[ENT_P] && (!wrReg || memWdata[ENT_D])));
  // R10: a base write leaves the cache empty
  assert_flush_R10: assert property (@(posedge clk) disable iff (!rstN)
    dirBaseWe |=> !cValid);
endmodule

// File: rtl/page_walker.sv
module page_walker
  import pw_pkg::*;
#(
  parameter int PG_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [PG_W*3-5:0]  reqAddr,
  input  logic               reqWrite,
  input  logic               reqUser,
  input  logic               pagingOn,
  input  logic               dirBaseWe,
  input  logic [PG_W*3-5:0]  dirBaseIn,
  output logic               memValid,
  input  logic               memReady,
  output logic               memWe,
  output logic [PG_W*3-5:0]  memAddr,
  output logic [PG_W*3-5:0]  memWdata,
  input  logic [PG_W*3-5:0]  memRdata,
  output logic               doneValid,
  output logic [PG_W*3-5:0]  physAddr,
  output logic               faultValid,
  output logic [2:0]         faultCode,
  output logic [PG_W*3-5:0]  faultAddr
);
  strobes_t st;
  status_t  stat;

  pw_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .pagingOn(pagingOn),
    .memReady(memReady), .stat(stat), .st(st), .reqReady(reqReady),
    .memValid(memValid), .memWe(memWe), .doneValid(doneValid), .faultValid(faultValid)
  );

  pw_dpath #(.PG_W(PG_W)) i_dpath (
    .clk(clk), .rstN(rstN), .st(st), .stat(stat), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqUser(reqUser), .dirBaseWe(dirBaseWe),
    .dirBaseIn(dirBaseIn), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .physAddr(physAddr), .faultCode(faultCode),
    .faultAddr(faultAddr)
  );

  // R1: bypass when paging is off
  assert_bypass_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !pagingOn) |=> (doneValid && physAddr == $past(reqAddr)));
  // R11: memory request held until ready
  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memWe) && $stable(memAddr) && $stable(memWdata)));
endmodule

// File: tb/test_page_walker.sv
`timescale 1ns/1ps
module test_page_walker;
  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqUser = 1'b0, pagingOn = 1'b1;
  logic dirBaseWe = 1'b0;
  logic [31:0] reqAddr = '0, dirBaseIn = '0;
  logic reqReady, memValid, memWe, doneValid, faultValid;
  logic memReady = 1'b1;
  logic [31:0] memAddr, memWdata, memRdata, physAddr, faultAddr;
  logic [2:0] faultCode;

  logic [31:0] mem [0:4095];
  int reads = 0, writes = 0, tests = 0, fails = 0, cyc = 0;
  logic stallMode = 1'b0;

  // results of the last request
  logic gotDone, gotFault;
  logic [31:0] gotPa, gotFa;
  logic [2:0] gotCode;
  int lat;

  always #2 clk = ~clk;

  page_walker i_page_walker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqUser(reqUser), .pagingOn(pagingOn), .dirBaseWe(dirBaseWe),
    .dirBaseIn(dirBaseIn), .memValid(memValid), .memReady(memReady), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .doneValid(doneValid),
    .physAddr(physAddr), .faultValid(faultValid), .faultCode(faultCode), .faultAddr(faultAddr)
  );

  assign memRdata = mem[memAddr[13:2]];

  always @(posedge clk) begin
    if (memValid && memReady) begin
      if (memWe) begin
        mem[memAddr[13:2]] <= memWdata;
        writes <= writes + 1;
      end else begin
        reads <= reads + 1;
      end
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    memReady <= !stallMode || (cyc % 3 == 0);
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic flush(input logic [31:0] val);
    @(negedge clk);
    dirBaseWe = 1'b1; dirBaseIn = val;
    @(negedge clk);
    dirBaseWe = 1'b0;
  endtask

  // flushAt: 0 none, 1 one cycle into the request, 2 in the done cycle
  task automatic doReq(input logic [31:0] la, input logic w, input logic u, input int flushAt);
    @(negedge clk);
    reads = 0; writes = 0;
    reqValid = 1'b1; reqAddr = la; reqWrite = w; reqUser = u;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    if (flushAt == 1) begin dirBaseWe = 1'b1; dirBaseIn = 32'h1000; end
    while (!(doneValid || faultValid) && lat < 200) begin
      @(negedge clk);
      dirBaseWe = 1'b0;
      lat++;
    end
    if (lat >= 200) chk(1'b0, "watchdog", lat, 0);
    gotDone = doneValid; gotFault = faultValid;
    gotPa = physAddr; gotFa = faultAddr; gotCode = faultCode;
    if (flushAt == 2) begin dirBaseWe = 1'b1; dirBaseIn = 32'h1000; end
    if (dirBaseWe) begin @(negedge clk); dirBaseWe = 1'b0; end
  endtask

  initial begin
    for (int k = 0; k < 4096; k++) mem[k] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !doneValid && !faultValid && !memValid, "R12 reset state",
        {reqReady, doneValid, faultValid, memValid}, 32'h8);

    // R1: bypass
    pagingOn = 1'b0;
    for (int k = 0; k < 3; k++) begin
      logic [31:0] la;
      la = 32'hDEADBEEF ^ (32'h13579BDF * k);
      doReq(la, k[0], k[1], 0);
      chk(gotDone && gotPa == la, "R1 bypass address", gotPa, la);
      chk(lat == 1 && reads == 0 && writes == 0, "R1 bypass latency/no access", lat * 256 + reads, 1 * 256);
    end
    pagingOn = 1'b1;

    // exhaustive sweep of entry bits, access kinds and prior A/D states
    for (int i = 0; i < 2048; i++) begin
      logic [2:0] pdeBits, pteBits;
      logic w, u, pdeA, pteA, pteD, eDone, eProt;
      logic [9:0] dIdx, tIdx;
      logic [11:0] off;
      logic [31:0] tblBase, pde, pte, la, ePde, ePte, ePa;
      logic [19:0] frame;
      int eWr;
      pdeBits = i[2:0]; pteBits = i[5:3];
      w = i[6]; u = i[7]; pdeA = i[8]; pteA = i[9]; pteD = i[10];
      dIdx = 10'((i * 37) % 1024);
      tIdx = 10'((i * 91 + 3) % 1024);
      off = 12'((i * 13) & 12'hFFF);
      frame = 20'h40000 + 20'(i);
      tblBase = (i % 5 < 2) ? 32'h2000 : 32'h3000;
      pde = tblBase | (32'(pdeA) << 5) | 32'(pdeBits);
      pte = {frame, 12'h000} | (32'(pteD) << 6) | (32'(pteA) << 5) | 32'(pteBits);
      la = {dIdx, tIdx, off};
      mem[32'h400 + dIdx] = pde;
      mem[(tblBase >> 2) + tIdx] = pte;
      stallMode = (i % 4 == 1);
      flush(32'h1000 | (32'(i) & 32'hFFF));
      doReq(la, w, u, 0);

      // expected outcome from the rules
      ePde = pde; ePte = pte; eWr = 0; eDone = 1'b0; eProt = 1'b0; ePa = '0;
      if (!pdeBits[0]) begin
        eProt = 1'b0;
      end else if (u && (!pdeBits[2] || (w && !pdeBits[1]))) begin
        eProt = 1'b1;
      end else begin
        ePde = pde | 32'h20;
        eWr = pdeA ? 0 : 1;
        if (!pteBits[0]) eProt = 1'b0;
        else if (u && (!(pdeBits[2] & pteBits[2]) || (w && !(pdeBits[1] & pteBits[1])))) eProt = 1'b1;
        else begin
          eDone = 1'b1;
          ePa = {frame, off};
          ePte = pte | 32'h20 | (w ? 32'h40 : 32'h0);
          if (!pteA || (w && !pteD)) eWr++;
        end
      end
      if (eDone) begin
        chk(gotDone && !gotFault, "R5 access allowed", {gotDone, gotFault}, 2);
        chk(gotPa == ePa, "R2 R3 physical address", gotPa, ePa);
      end else begin
        chk(gotFault && !gotDone, "R4 R5 fault raised", {gotDone, gotFault}, 1);
        chk(gotCode == {u, w, eProt}, "R6 R4 R5 error code", gotCode, {u, w, eProt});
        chk(gotFa == la, "R6 fault address", gotFa, la);
      end
      chk(mem[32'h400 + dIdx] == ePde, "R7 directory entry after walk", mem[32'h400 + dIdx], ePde);
      chk(mem[(tblBase >> 2) + tIdx] == ePte, "R7 R8 table entry after walk",
          mem[(tblBase >> 2) + tIdx], ePte);
      chk(writes == eWr, "R7 R8 write-back count", writes, eWr);
    end
    stallMode = 1'b0;

    // cache behaviour on page dir 5 / table 7
    mem[32'h400 + 5] = 32'h2007;
    mem[32'h800 + 7] = 32'h12345007;
    flush(32'h1000);
    doReq(32'h01407ABC, 1'b0, 1'b0, 0);
    chk(gotDone && gotPa == 32'h12345ABC, "R2 walk before caching", gotPa, 32'h12345ABC);
    chk(writes == 2, "R7 both accessed bits written", writes, 2);
    doReq(32'h01407123, 1'b0, 1'b0, 0);
    chk(gotDone && gotPa == 32'h12345123 && lat == 1, "R9 cached read", gotPa, 32'h12345123);
    chk(reads == 0 && writes == 0, "R9 no traffic on hit", reads, 0);
    doReq(32'h01407456, 1'b0, 1'b1, 0);
    chk(gotDone && lat == 1 && reads == 0, "R9 cached user read", lat, 1);
    doReq(32'h01407008, 1'b1, 1'b0, 0);
    chk(gotDone && reads == 2 && writes == 1, "R8 write with clean cache walks", reads * 16 + writes, 32'h21);
    chk(mem[32'h800 + 7] == 32'h12345067, "R8 dirty written", mem[32'h800 + 7], 32'h12345067);
    doReq(32'h01407010, 1'b1, 1'b1, 0);
    chk(gotDone && lat == 1 && reads == 0 && writes == 0, "R9 cached user write", lat, 1);
    flush(32'h1FFF);
    doReq(32'h01407020, 1'b0, 1'b0, 0);
    chk(gotDone && gotPa == 32'h12345020 && reads == 2, "R10 flush forces walk, low base bits cleared",
        gotPa, 32'h12345020);
    stallMode = 1'b1;
    doReq(32'h01407030, 1'b0, 1'b0, 1);
    stallMode = 1'b0;
    doReq(32'h01407040, 1'b0, 1'b0, 0);
    chk(gotDone && reads == 2, "R10 flush during walk blocks fill", reads, 2);
    doReq(32'h01407050, 1'b0, 1'b0, 0);
    chk(gotDone && reads == 0 && lat == 1, "R9 control repeat hits", reads, 0);
    flush(32'h1000);
    doReq(32'h01407060, 1'b0, 1'b0, 2);
    doReq(32'h01407070, 1'b0, 1'b0, 0);
    chk(gotDone && reads == 2, "R10 flush in fill cycle wins", reads, 2);

    // cached supervisor-only page refused to user
    mem[32'h800 + 7] = 32'h12345063;
    flush(32'h1000);
    doReq(32'h01407080, 1'b0, 1'b0, 0);
    doReq(32'h01407090, 1'b0, 1'b1, 0);
    chk(gotFault && gotCode == 3'b101 && gotFa == 32'h01407090, "R5 R9 user miss on supervisor page",
        {gotCode, gotFa[27:0]}, {3'b101, 28'h1407090});
    chk(reads == 2, "R9 permission miss walks", reads, 2);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", tests);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule